// File: doc/BRIEF.md
# Integer Exception and Condition Flags

This block keeps the three integer exception flags of a processor core: a sticky summary overflow, an overflow and a carry. It also builds the 4-bit condition field that an integer instruction records when asked to. The execute stage reports each finished integer operation with a valid strobe and an operation class. It also supplies both operands, the result, and the carries into and out of the top result bit. Each flag follows its own rules for each class. Some classes write a flag, others leave it alone, and overflow always feeds the sticky summary bit.

Software reaches the flags in two ways. A full register write loads every field, including a 7-bit byte count used by string moves. A copy-and-clear request hands back the three flags as a 4-bit value and zeroes them in the same cycle. The whole 32-bit register is always visible on a read port, and its reserved bits read as zero.

Top module: `xfl_flags`

## Requirements
- R1: Summary overflow (register bit 31) is sticky. An operation that sets overflow also sets it. Nothing clears it except a software write or a copy-and-clear.
- R2: For add, subtract or negate (class 1) and carrying add or subtract (class 2) with `ovf_en` high, overflow (bit 30) becomes `msb_cin ^ msb_cout`. With `ovf_en` low, overflow is unchanged.
- R3: For multiply-low (class 3) with `ovf_en` high, overflow is set when the signed 64-bit product of the operands does not fit in 32 signed bits. Otherwise it is cleared.
- R4: For divide (class 4) with `ovf_en` high, overflow is set for a zero divisor. It is also set, when `is_signed` is high, for 0x80000000 divided by 0xFFFFFFFF. Otherwise it is cleared.
- R5: For a carrying add or subtract (class 2), carry (bit 29) becomes `msb_cout`. Classes 1, 3 and 4 leave carry unchanged.
- R6: For an arithmetic right shift (class 5) of `opnd_a` by `opnd_b[5:0]` places (32 or more shifts out every bit), carry is set only when `opnd_a` is negative and a 1 bit was shifted out. Otherwise it is cleared.
- R7: Compare (class 6) and other operations (classes 0 and 7) leave all three flags unchanged.
- R8: When `op_valid` and `rec_en` are high, `cond_field` = {LT, GT, EQ, SO} and `cond_vld` pulses high in the following cycle. LT is set for a negative result, GT for a positive non-zero result and EQ for a zero result. SO is the summary overflow after the operation's own update.
- R9: For a compare (class 6), LT/GT/EQ compare `opnd_a` with `opnd_b`, as signed values when `is_signed` is high and as unsigned values when it is low.
- R10: A software write loads bit 31 (summary overflow), bit 30 (overflow), bit 29 (carry) and bits 6:0 (byte count) from `sw_data`. Every other bit of `flags_word` reads 0.
- R11: While `mv_req` is high, `mv_data` shows {summary overflow, overflow, carry, 0} combinationally. At the next edge those three flags clear and the byte count is kept.
- R12: In the same cycle, a software write beats copy-and-clear, and copy-and-clear beats an operation's flag update. Reset clears every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An integer operation completes this cycle |
| op_class | input | 3 | 0 other, 1 add/sub/neg, 2 carrying add/sub, 3 multiply-low, 4 divide, 5 arithmetic shift right, 6 compare |
| ovf_en | input | 1 | Operation requests overflow update |
| rec_en | input | 1 | Operation records a condition field |
| is_signed | input | 1 | Signed divide / signed compare |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or shift amount |
| result | input | 32 | Operation result |
| msb_cin | input | 1 | Carry into the top result bit |
| msb_cout | input | 1 | Carry out of the top result bit |
| sw_wr | input | 1 | Full software register write |
| sw_data | input | 32 | Software write data |
| mv_req | input | 1 | Copy-and-clear request |
| mv_data | output | 4 | {SO, OV, CA, 0} before clearing |
| flags_word | output | 32 | Register contents |
| cond_vld | output | 1 | Condition field recorded last cycle |
| cond_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The assertions check several rules on every cycle. Summary overflow cannot drop without a write or a clear. A compare never disturbs the flags. A recorded condition has exactly one of LT/GT/EQ set. A software write lands exactly, a copy-and-clear empties the flags, and a zero-divisor divide raises overflow. The directed scenarios are needed for the arithmetic corners: carries from shifts of positive, negative and over-wide amounts, the multiply boundary, the signed and unsigned divide corner, and signed against unsigned compare. They also cover the same-cycle priority among write, clear and operation update.

// File: rtl/xfl_pkg.sv
package xfl_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 7;
    localparam int SO_BIT  = 31;
    localparam int OV_BIT  = 30;
    localparam int CA_BIT  = 29;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_ADD   = 3'd1,
        CLS_ADDC  = 3'd2,
        CLS_MUL   = 3'd3,
        CLS_DIV   = 3'd4,
        CLS_SRA   = 3'd5,
        CLS_CMP   = 3'd6,
        CLS_RSV   = 3'd7
    } op_cls_e;

    typedef struct packed {
        logic             so;
        logic             ov;
        logic             ca;
        logic [CNT_W-1:0] cnt;
        logic             cvld;
        logic [3:0]       cond;
    } xfl_state_t;
endpackage

// File: rtl/xfl_ovf_calc.sv
module xfl_ovf_calc
    import xfl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op_class,
    input  logic          ovf_en,
    input  logic          is_signed,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          msb_cin,
    input  logic          msb_cout,
    output logic          ov_wr,
    output logic          ov_val
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [PW-1:0] prod_d;
    logic [DW:0]   prod_hi_d;
    logic          mul_ovf_d;
    logic          div_ovf_d;

    always_comb begin
        prod_d    = {{DW{opnd_a[DW-1]}}, opnd_a} * {{DW{opnd_b[DW-1]}}, opnd_b};
        prod_hi_d = prod_d[PW-1:DW-1];
        mul_ovf_d = !((&prod_hi_d) || !(|prod_hi_d));
        div_ovf_d = (opnd_b == '0) ||
                    (is_signed && opnd_a == MOST_NEG && opnd_b == '1);
        ov_wr  = 1'b0;
        ov_val = 1'b0;
        if (ovf_en) begin
            case (op_class)
                CLS_ADD, CLS_ADDC: begin ov_wr = 1'b1; ov_val = msb_cin ^ msb_cout; end
                CLS_MUL:           begin ov_wr = 1'b1; ov_val = mul_ovf_d; end
                CLS_DIV:           begin ov_wr = 1'b1; ov_val = div_ovf_d; end
                default:           begin ov_wr = 1'b0; ov_val = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/xfl_carry_calc.sv
module xfl_carry_calc
    import xfl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op_class,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          msb_cout,
    output logic          ca_wr,
    output logic          ca_val
);
    localparam int SHW = $clog2(DW) + 1;

    logic [SHW-1:0] amt_d;
    logic [DW-1:0]  lost_mask_d;
    logic           lost_one_d;

    always_comb begin
        amt_d = opnd_b[SHW-1:0];
        if (int'(amt_d) >= DW) lost_mask_d = '1;
        else                   lost_mask_d = (DW'(1) << amt_d) - DW'(1);
        lost_one_d = |(opnd_a & lost_mask_d);
        case (op_class)
            CLS_ADDC: begin ca_wr = 1'b1; ca_val = msb_cout; end
            CLS_SRA:  begin ca_wr = 1'b1; ca_val = opnd_a[DW-1] && lost_one_d; end
            default:  begin ca_wr = 1'b0; ca_val = 1'b0; end
        endcase
    end
endmodule

// File: rtl/xfl_cond_gen.sv
module xfl_cond_gen
    import xfl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op_class,
    input  logic          is_signed,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] result,
    input  logic          so_after,
    output logic [3:0]    cond
);
    logic lt_d, gt_d, eq_d;

    always_comb begin
        if (op_class == CLS_CMP) begin
            eq_d = (opnd_a == opnd_b);
            if (is_signed) lt_d = $signed(opnd_a) < $signed(opnd_b);
            else           lt_d = opnd_a < opnd_b;
        end else begin
            eq_d = (result == '0);
            lt_d = result[DW-1];
        end
        gt_d = !lt_d && !eq_d;
        cond = {lt_d, gt_d, eq_d, so_after};
    end
endmodule

// File: rtl/xfl_flags.sv
module xfl_flags
    import xfl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_class,
    input  logic          ovf_en,
    input  logic          rec_en,
    input  logic          is_signed,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] result,
    input  logic          msb_cin,
    input  logic          msb_cout,
    input  logic          sw_wr,
    input  logic [31:0]   sw_data,
    input  logic          mv_req,
    output logic [3:0]    mv_data,
    output logic [31:0]   flags_word,
    output logic          cond_vld,
    output logic [3:0]    cond_field
);
    logic       ov_wr, ov_val, ca_wr, ca_val;
    logic       so_after_op;
    logic [3:0] cond_new;
    xfl_state_t st_d, st_q;

    xfl_ovf_calc #(.DW(DW)) u_ovf (
        .op_class(op_class), .ovf_en(ovf_en), .is_signed(is_signed),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .msb_cin(msb_cin),
        .msb_cout(msb_cout), .ov_wr(ov_wr), .ov_val(ov_val)
    );

    xfl_carry_calc #(.DW(DW)) u_carry (
        .op_class(op_class), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .msb_cout(msb_cout), .ca_wr(ca_wr), .ca_val(ca_val)
    );

    xfl_cond_gen #(.DW(DW)) u_cond (
        .op_class(op_class), .is_signed(is_signed), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .result(result), .so_after(so_after_op),
        .cond(cond_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cvld = 1'b0;
        so_after_op = st_q.so || (op_valid && ov_wr && ov_val);
        if (op_valid) begin
            if (ov_wr) st_d.ov = ov_val;
            if (ca_wr) st_d.ca = ca_val;
            st_d.so = so_after_op;
            if (rec_en) begin
                st_d.cvld = 1'b1;
                st_d.cond = cond_new;
            end
        end
        if (mv_req) begin
            st_d.so = 1'b0;
            st_d.ov = 1'b0;
            st_d.ca = 1'b0;
        end
        if (sw_wr) begin
            st_d.so  = sw_data[SO_BIT];
            st_d.ov  = sw_data[OV_BIT];
            st_d.ca  = sw_data[CA_BIT];
            st_d.cnt = sw_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags_word              = '0;
        flags_word[SO_BIT]      = st_q.so;
        flags_word[OV_BIT]      = st_q.ov;
        flags_word[CA_BIT]      = st_q.ca;
        flags_word[CNT_W-1:0]   = st_q.cnt;
        mv_data    = {st_q.so, st_q.ov, st_q.ca, 1'b0};
        cond_vld   = st_q.cvld;
        cond_field = st_q.cond;
    end

    // R1: summary overflow only drops through write or clear
    a_r1_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_word[SO_BIT] && !sw_wr && !mv_req) |=> flags_word[SO_BIT]);

    // R7: compare leaves all flags alone
    a_r7_cmp_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_CMP && !sw_wr && !mv_req)
        |=> $stable(flags_word[SO_BIT:CA_BIT]));

    // R8: exactly one relation bit in a recorded field
    a_r8_cond_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        cond_vld |-> ($countones(cond_field[3:1]) == 1));

    // R10: a software write lands exactly with reserved bits zero
    a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> flags_word == ($past(sw_data) & 32'hE000_007F));

    // R11: copy-and-clear empties the three flags
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !sw_wr) |=> (flags_word[SO_BIT:CA_BIT] == 3'b000));

    // R4: zero divisor with overflow enable raises overflow and summary
    a_r4_div_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_DIV && ovf_en && opnd_b == '0 && !sw_wr && !mv_req)
        |=> (flags_word[OV_BIT] && flags_word[SO_BIT]));
endmodule

// File: tb/xfl_flags_test.sv
module xfl_flags_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = '0;
    logic        ovf_en = 1'b0, rec_en = 1'b0, is_signed = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic        msb_cin = 1'b0, msb_cout = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_data = '0;
    logic        mv_req = 1'b0;
    logic [3:0]  mv_data;
    logic [31:0] flags_word;
    logic        cond_vld;
    logic [3:0]  cond_field;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfl_flags uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .ovf_en(ovf_en), .rec_en(rec_en), .is_signed(is_signed),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .msb_cin(msb_cin), .msb_cout(msb_cout), .sw_wr(sw_wr),
        .sw_data(sw_data), .mv_req(mv_req), .mv_data(mv_data),
        .flags_word(flags_word), .cond_vld(cond_vld), .cond_field(cond_field)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // drive one operation for one cycle; outputs valid at the following negedge
    task automatic do_op(input logic [2:0] cls, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] res, input logic ci, input logic co,
                         input logic oe, input logic rc, input logic sg);
        @(negedge clk);
        op_valid = 1'b1; op_class = cls; opnd_a = a; opnd_b = b; result = res;
        msb_cin = ci; msb_cout = co; ovf_en = oe; rec_en = rc; is_signed = sg;
        @(negedge clk);
        op_valid = 1'b0; rec_en = 1'b0;
    endtask

    task automatic sw_write(input logic [31:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_data = d;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic copy_clear(input logic [3:0] exp_mv, input string tag);
        @(negedge clk);
        mv_req = 1'b1;
        #1 chk(tag, 32'(mv_data), 32'(exp_mv));
        @(negedge clk);
        mv_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 reset word", flags_word, 32'h0);
        chk("R12 reset cond_vld", 32'(cond_vld), 32'h0);
        chk("R12 reset mv_data", 32'(mv_data), 32'h0);
    endtask

    task automatic t_add;
        do_op(3'd1, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1, 0, 1, 1, 0);
        chk("R2 add overflow", flags_word, 32'hC000_0000);
        chk("R8 cond LT+SO", 32'(cond_field), 32'h9);
        chk("R8 cond_vld", 32'(cond_vld), 32'h1);
        do_op(3'd1, 32'h1, 32'h2, 32'h3, 0, 0, 1, 1, 0);
        chk("R1 sticky SO after clean add", flags_word, 32'h8000_0000);
        chk("R8 cond GT+SO", 32'(cond_field), 32'h5);
        copy_clear(4'b1000, "R11 mv_data");
        chk("R11 cleared", flags_word, 32'h0);
        do_op(3'd1, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1, 0, 0, 0, 0);
        chk("R2 ovf_en low keeps OV", flags_word, 32'h0);
        chk("R8 no record pulse", 32'(cond_vld), 32'h0);
    endtask

    task automatic t_carry_and_cmp;
        do_op(3'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 1, 1, 0, 1, 0);
        chk("R5 carrying add sets CA", flags_word, 32'h2000_0000);
        chk("R8 cond EQ", 32'(cond_field), 32'h2);
        do_op(3'd1, 32'h1, 32'h1, 32'h2, 0, 0, 1, 0, 0);
        chk("R5 plain add keeps CA", flags_word, 32'h2000_0000);
        do_op(3'd6, 32'd5, 32'd9, 32'h0, 1, 1, 1, 1, 1);
        chk("R7 compare keeps flags", flags_word, 32'h2000_0000);
        chk("R9 signed 5<9", 32'(cond_field), 32'h8);
        do_op(3'd6, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 0, 1, 0);
        chk("R9 unsigned GT", 32'(cond_field), 32'h4);
        do_op(3'd6, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 0, 1, 1);
        chk("R9 signed LT", 32'(cond_field), 32'h8);
        do_op(3'd0, 32'h7FFF_FFFF, 32'h0, 32'h1, 1, 0, 1, 0, 0);
        chk("R7 other class keeps flags", flags_word, 32'h2000_0000);
        copy_clear(4'b0010, "R11 mv_data CA");
    endtask

    task automatic t_sra;
        do_op(3'd5, 32'h8000_0001, 32'd1, 32'hC000_0000, 0, 0, 0, 0, 0);
        chk("R6 negative, one lost", flags_word, 32'h2000_0000);
        do_op(3'd5, 32'h8000_0000, 32'd4, 32'hF800_0000, 0, 0, 0, 0, 0);
        chk("R6 negative, zeros lost", flags_word, 32'h0);
        do_op(3'd5, 32'hFFFF_FFFF, 32'd40, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        chk("R6 over-wide shift", flags_word, 32'h2000_0000);
        do_op(3'd5, 32'h0000_0001, 32'd1, 32'h0, 0, 1, 0, 0, 0);
        chk("R6 positive operand", flags_word, 32'h0);
    endtask

    task automatic t_mul_div;
        do_op(3'd3, 32'h0001_0000, 32'h0001_0000, 32'h0, 0, 0, 1, 0, 0);
        chk("R3 multiply overflow", flags_word, 32'hC000_0000);
        do_op(3'd3, 32'hFFFF_FFFE, 32'd3, 32'hFFFF_FFFA, 0, 0, 1, 1, 0);
        chk("R3 negative product fits", flags_word, 32'h8000_0000);
        chk("R8 cond LT with sticky SO", 32'(cond_field), 32'h9);
        copy_clear(4'b1000, "R11 mv_data SO only");
        do_op(3'd4, 32'd7, 32'd0, 32'h0, 0, 0, 1, 0, 0);
        chk("R4 divide by zero", flags_word, 32'hC000_0000);
        copy_clear(4'b1100, "R11 mv_data SO OV");
        do_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 0, 0, 1, 0, 0);
        chk("R4 unsigned corner fits", flags_word, 32'h0);
        do_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 0, 0, 1, 0, 1);
        chk("R4 signed corner overflows", flags_word, 32'hC000_0000);
    endtask

    task automatic t_sw_priority;
        sw_write(32'hFFFF_FFFF);
        chk("R10 write all ones", flags_word, 32'hE000_007F);
        copy_clear(4'b1110, "R11 mv_data all");
        chk("R11 count kept", flags_word, 32'h0000_007F);
        @(negedge clk);
        sw_wr = 1'b1; sw_data = 32'h0000_0005;
        op_valid = 1'b1; op_class = 3'd2; msb_cout = 1'b1; msb_cin = 1'b0; ovf_en = 1'b1;
        mv_req = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0; op_valid = 1'b0; mv_req = 1'b0;
        chk("R12 write beats op and clear", flags_word, 32'h0000_0005);
        @(negedge clk);
        op_valid = 1'b1; op_class = 3'd2; msb_cout = 1'b1; msb_cin = 1'b0; ovf_en = 1'b1;
        mv_req = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; mv_req = 1'b0;
        chk("R12 clear beats op", flags_word, 32'h0000_0005);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_carry_and_cmp();
        t_sra();
        t_mul_div();
        t_sw_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule